// File: doc/BRIEF.md
# First-Level Descriptor Fetch with Split Table Base

This block turns a translation miss into one first-level descriptor read. A 32-bit virtual address arrives on a valid/ready port. A programmable split count decides which of two table base registers serves the address. The block forms the word address of the descriptor, makes a single read on a simple memory port, and returns the raw descriptor word. With the descriptor it returns the index of the base that was used and a flag for a translation fault.

The split count N runs from 0 to 7. When N is zero, every address uses the low table, and the low table is a full 16 KB table. When N is above zero, only addresses whose top N bits are all zero go to the low table. That table then shrinks to 16 KB >> N, and its base alignment shrinks with it. The high table is always a full 16 KB table on a 16 KB boundary.

Software writes the two bases and the split count through a small write port. Each accepted write raises a one-cycle flush request, so that any cached translations can be discarded.

Top module: `table_base_walker`

## Requirements
- R1: After reset the split count is 0, both bases are 0, missReady is 1, and memReqValid, descValid and flushReq are 0.
- R2: With split count 0, every lookup reports base index 0, whatever the address bits are.
- R3: With split count N > 0, a lookup uses base 0 when virtual address bits [31:32-N] are all zero, and base 1 otherwise. descBaseSel reports the index: 0 for base 0, 1 for base 1.
- R4: A base-1 lookup reads address (base1 with bits [13:0] cleared) OR (VA[31:20] << 2).
- R5: A base-0 lookup reads address (base0 with its low log2(16 KB >> N) bits cleared) OR (VA[31-N:20] << 2). The alignment follows the split count in force when the miss is accepted.
- R6: Register writes use cfgAddr 0 for base 0, 1 for base 1 and 2 for the split count (cfgWrData[2:0]). Base-1 write bits [13:0] and base-0 write bits [6:0] are discarded. A write with cfgAddr 3 changes nothing.
- R7: A miss is accepted on a clock edge where missValid and missReady are both 1. memReqValid is then 1 for exactly the next cycle. missReady stays 0 from acceptance until the descriptor is handed back, so only one walk is outstanding.
- R8: memRspValid is honoured from the cycle after memReqValid onward. In the cycle after the response, descValid is 1 for one cycle, with descData equal to the returned word and descBaseSel equal to the base index chosen at acceptance.
- R9: descFault is 1 with the descriptor exactly when descriptor bits [1:0] are 00.
- R10: A write with cfgAddr 0, 1 or 2 makes flushReq 1 for the single following cycle. A write with cfgAddr 3 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| missValid | input | 1 | Translation miss present |
| missReady | output | 1 | Block can accept a miss |
| missVa | input | 32 | Virtual address of the miss |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register select: 0 base 0, 1 base 1, 2 split count |
| cfgWrData | input | 32 | Register write data |
| flushReq | output | 1 | One-cycle request to flush cached translations |
| memReqValid | output | 1 | Descriptor read request (one cycle) |
| memReqAddr | output | 32 | Descriptor byte address |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Returned descriptor word |
| descValid | output | 1 | Descriptor handed back (one cycle) |
| descData | output | 32 | Raw descriptor |
| descBaseSel | output | 1 | Base index used for this walk |
| descFault | output | 1 | Descriptor type is a translation fault |

## Verification
A corrupt split count or base register shows up at the port on the next read, in memReqAddr one cycle after the miss is accepted. It appears as wrong upper bits or a wrong alignment mask, or as a base index that differs when descValid comes. A stuck walk state shows at once: missReady stays low, or memReqValid lasts more than one cycle, or descValid does not come in the cycle after the response. The bench model predicts every output on every cycle, so any of these differences is reported within one cycle of the edge that caused it.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_REQ  = 2'd1,
    W_WAIT = 2'd2
  } walkState_t;

  typedef struct packed {
    logic capture;
    logic deliver;
  } walkStrobe_t;
endpackage

// File: rtl/tbw_control.sv
module tbw_control
  import tbw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missValid,
  input  logic        memRspValid,
  output logic        missReady,
  output logic        memReqValid,
  output walkStrobe_t strobe
);
  walkState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      W_IDLE:  if (missValid) stateD = W_REQ;
      W_REQ:   stateD = W_WAIT;
      W_WAIT:  if (memRspValid) stateD = W_IDLE;
      default: stateD = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= W_IDLE;
    else       stateQ <= stateD;
  end

  assign missReady      = (stateQ == W_IDLE);
  assign memReqValid    = (stateQ == W_REQ);
  assign strobe.capture = (stateQ == W_IDLE) && missValid;
  assign strobe.deliver = (stateQ == W_WAIT) && memRspValid;
endmodule

// File: rtl/tbw_datapath.sv
module tbw_datapath
  import tbw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SPLIT_W    = 3,
  parameter int ENTRY_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [ADDR_W-1:0] missVa,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              flushReq,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              descValid,
  output logic [ADDR_W-1:0] descData,
  output logic              descBaseSel,
  output logic              descFault
);
  localparam int IDX_W     = ADDR_W - ENTRY_LOG2;
  localparam int FULL_LOG2 = IDX_W + 2;
  localparam int MAX_SPLIT = (1 << SPLIT_W) - 1;
  localparam int MIN_LOG2  = FULL_LOG2 - MAX_SPLIT;

  logic [ADDR_W-1:MIN_LOG2]  base0Q;
  logic [ADDR_W-1:FULL_LOG2] base1Q;
  logic [SPLIT_W-1:0]        splitQ;
  logic                      flushQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base0Q <= '0;
      base1Q <= '0;
      splitQ <= '0;
      flushQ <= 1'b0;
    end else begin
      flushQ <= cfgWrEn && (cfgAddr != 2'd3);
      if (cfgWrEn) begin
        unique case (cfgAddr)
          2'd0:    base0Q <= cfgWrData[ADDR_W-1:MIN_LOG2];
          2'd1:    base1Q <= cfgWrData[ADDR_W-1:FULL_LOG2];
          2'd2:    splitQ <= cfgWrData[SPLIT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // Base choice: any set bit among the top splitQ address bits selects base 1.
  logic [ADDR_W-1:0] topMask;
  logic              useHigh;
  logic [IDX_W-1:0]  vaIdx;
  logic [IDX_W-1:0]  idxMask0;
  logic [ADDR_W-1:0] sizeMask0;
  logic [ADDR_W-1:0] base0Full;
  logic [ADDR_W-1:0] base1Full;
  logic [ADDR_W-1:0] addr0;
  logic [ADDR_W-1:0] addr1;

  always_comb begin
    topMask   = ~({ADDR_W{1'b1}} >> splitQ);
    useHigh   = |(missVa & topMask);
    vaIdx     = missVa[ADDR_W-1:ENTRY_LOG2];
    idxMask0  = {IDX_W{1'b1}} >> splitQ;
    sizeMask0 = (ADDR_W'(1) << (FULL_LOG2 - 32'(splitQ))) - ADDR_W'(1);
    base0Full = {base0Q, {MIN_LOG2{1'b0}}};
    base1Full = {base1Q, {FULL_LOG2{1'b0}}};
    addr0     = (base0Full & ~sizeMask0) | ADDR_W'({vaIdx & idxMask0, 2'b00});
    addr1     = base1Full | ADDR_W'({vaIdx, 2'b00});
  end

  logic [ADDR_W-1:0] reqAddrQ;
  logic              selQ;
  logic [ADDR_W-1:0] descQ;
  logic              descValidQ;
  logic              faultQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddrQ   <= '0;
      selQ       <= 1'b0;
      descQ      <= '0;
      descValidQ <= 1'b0;
      faultQ     <= 1'b0;
    end else begin
      descValidQ <= strobe.deliver;
      if (strobe.capture) begin
        reqAddrQ <= useHigh ? addr1 : addr0;
        selQ     <= useHigh;
      end
      if (strobe.deliver) begin
        descQ  <= memRspData;
        faultQ <= (memRspData[1:0] == 2'b00);
      end
    end
  end

  assign flushReq    = flushQ;
  assign memReqAddr  = reqAddrQ;
  assign descValid   = descValidQ;
  assign descData    = descQ;
  assign descBaseSel = selQ;
  assign descFault   = faultQ;
endmodule

// File: rtl/table_base_walker.sv
module table_base_walker
  import tbw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SPLIT_W    = 3,
  parameter int ENTRY_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  output logic              missReady,
  input  logic [ADDR_W-1:0] missVa,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWrData,
  output logic              flushReq,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              descValid,
  output logic [ADDR_W-1:0] descData,
  output logic              descBaseSel,
  output logic              descFault
);
  walkStrobe_t strobe;

  tbw_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .missValid   (missValid),
    .memRspValid (memRspValid),
    .missReady   (missReady),
    .memReqValid (memReqValid),
    .strobe      (strobe)
  );

  tbw_datapath #(
    .ADDR_W     (ADDR_W),
    .SPLIT_W    (SPLIT_W),
    .ENTRY_LOG2 (ENTRY_LOG2)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .missVa      (missVa),
    .cfgWrEn     (cfgWrEn),
    .cfgAddr     (cfgAddr),
    .cfgWrData   (cfgWrData),
    .memRspData  (memRspData),
    .flushReq    (flushReq),
    .memReqAddr  (memReqAddr),
    .descValid   (descValid),
    .descData    (descData),
    .descBaseSel (descBaseSel),
    .descFault   (descFault)
  );
endmodule

// File: rtl/tbw_checker.sv
module tbw_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              missValid,
  input logic              missReady,
  input logic              cfgWrEn,
  input logic              flushReq,
  input logic              memReqValid,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              descValid
);
  p_issue_after_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && missReady) |=> (memReqValid && !missReady));

  p_single_request_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  p_busy_while_request_r7: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !missReady);

  p_desc_after_rsp_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memRspValid && !missReady && !memReqValid) |=> descValid);

  p_desc_needs_rsp_r8: assert property (@(posedge clk) disable iff (!rstN)
    descValid |-> $past(memRspValid));

  p_flush_needs_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> $past(cfgWrEn));

  p_word_aligned_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[1:0] == 2'b00));
endmodule

bind table_base_walker tbw_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .missValid   (missValid),
  .missReady   (missReady),
  .cfgWrEn     (cfgWrEn),
  .flushReq    (flushReq),
  .memReqValid (memReqValid),
  .memReqAddr  (memReqAddr),
  .memRspValid (memRspValid),
  .descValid   (descValid)
);

// File: tb/table_base_walker_bench.sv
`timescale 1ns/1ps
module table_base_walker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        missValid = 1'b0;
  logic        missReady;
  logic [31:0] missVa = '0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        flushReq;
  logic        memReqValid;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        descValid;
  logic [31:0] descData;
  logic        descBaseSel;
  logic        descFault;

  always #4 clk = ~clk;

  table_base_walker u_table_base_walker (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missReady(missReady),
    .missVa(missVa), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .flushReq(flushReq), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .descValid(descValid),
    .descData(descData), .descBaseSel(descBaseSel), .descFault(descFault)
  );

  int checks = 0;
  int failures = 0;
  string phaseTag = "R1";

  // Behavioural reference model state
  int          mPhase = 0;     // 0 waiting for miss, 1 issuing, 2 awaiting data
  logic [31:0] mB0 = '0, mB1 = '0;
  int          mN = 0;
  logic [31:0] mAddr = '0;
  bit          mSel = 0;
  bit          eFlush = 0, eDescValid = 0, eSel = 0, eFault = 0;
  logic [31:0] eDesc = '0;
  bit          started = 0;

  function automatic bit refHigh(logic [31:0] va, int n);
    if (n == 0) return 0;
    return (va >> (32 - n)) != 0;
  endfunction

  function automatic logic [31:0] refAddr(logic [31:0] va, int n, logic [31:0] b0, logic [31:0] b1);
    int tableBytes;
    if (refHigh(va, n)) return (b1 & ~32'h3FFF) | ((va >> 20) << 2);
    tableBytes = 16384 >> n;
    return (b0 & ~32'h7F & ~(tableBytes - 1)) | (((va >> 20) << 2) & (tableBytes - 1));
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mB0 = '0; mB1 = '0; mN = 0; mAddr = '0; mSel = 0;
      eFlush = 0; eDescValid = 0; eSel = 0; eFault = 0; eDesc = '0;
    end else begin
      eFlush = cfgWrEn && (cfgAddr != 2'd3);
      eDescValid = (mPhase == 2) && memRspValid;
      if (eDescValid) begin
        eDesc  = memRspData;
        eFault = (memRspData[1:0] == 2'b00);
        eSel   = mSel;
      end
      case (mPhase)
        0: if (missValid) begin
             mSel = refHigh(missVa, mN);
             mAddr = refAddr(missVa, mN, mB0, mB1);
             mPhase = 1;
           end
        1: mPhase = 2;
        default: if (memRspValid) mPhase = 0;
      endcase
      if (cfgWrEn) begin
        if (cfgAddr == 2'd0) mB0 = cfgWrData;
        else if (cfgAddr == 2'd1) mB1 = cfgWrData;
        else if (cfgAddr == 2'd2) mN = int'(cfgWrData[2:0]);
      end
    end
    started = 1;
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s (%s) %s: actual=%h expected=%h", req, phaseTag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(missReady === (mPhase == 0), "R7", "missReady", 32'(missReady), 32'(mPhase == 0));
      chk(memReqValid === (mPhase == 1), "R7", "memReqValid", 32'(memReqValid), 32'(mPhase == 1));
      if (mPhase == 1)
        chk(memReqAddr === mAddr, mSel ? "R4" : "R5", "memReqAddr", memReqAddr, mAddr);
      chk(flushReq === eFlush, "R10", "flushReq", 32'(flushReq), 32'(eFlush));
      chk(descValid === eDescValid, "R8", "descValid", 32'(descValid), 32'(eDescValid));
      if (eDescValid) begin
        chk(descData === eDesc, "R8", "descData", descData, eDesc);
        chk(descBaseSel === eSel, "R3", "descBaseSel", 32'(descBaseSel), 32'(eSel));
        chk(descFault === eFault, "R9", "descFault", 32'(descFault), 32'(eFault));
      end
    end
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic cfgWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic walk(logic [31:0] va, int lat, logic [31:0] rsp);
    @(negedge clk);
    missValid = 1'b1; missVa = va;
    @(negedge clk);
    missValid = 1'b0;
    repeat (lat) @(negedge clk);
    memRspValid = 1'b1; memRspData = rsp;
    @(negedge clk);
    memRspValid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(missReady === 1'b1 && memReqValid === 1'b0 && descValid === 1'b0 && flushReq === 1'b0,
        "R1", "reset outputs", {28'd0, missReady, memReqValid, descValid, flushReq}, 32'h8);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    phaseTag = "R1";
    walk(32'hFFF0_0000, 1, 32'h0000_0002);   // zero bases, split 0

    phaseTag = "R6";
    cfgWrite(2'd0, 32'h1234_5FFF);
    cfgWrite(2'd1, 32'h8000_7ABC);
    phaseTag = "R2";
    walk(32'hFFF0_0000, 1, 32'hAAAA_0001);
    walk(32'h8765_4321, 3, 32'h0000_0000);
    walk(32'h0010_0000, 2, 32'h5555_5556);

    phaseTag = "R3";
    cfgWrite(2'd2, 32'hFFFF_FFF2);          // split 2
    walk(32'h3FF0_0000, 1, 32'h1111_1112);
    walk(32'h4000_0000, 1, 32'h2222_2220);
    walk(32'hFFF0_0000, 2, 32'h3333_3333);

    phaseTag = "R5";
    cfgWrite(2'd2, 32'd6);
    walk(32'h03F0_0000, 1, 32'h0BAD_0000);
    walk(32'h0400_0000, 1, 32'h0BAD_0001);
    cfgWrite(2'd2, 32'd7);
    walk(32'h01F0_0000, 4, 32'h7777_7774);
    walk(32'h0200_0000, 1, 32'h7777_7775);

    phaseTag = "R6";
    cfgWrite(2'd3, 32'hFFFF_FFFF);          // no effect, no flush
    walk(32'h0100_0000, 1, 32'hCAFE_0002);
    cfgWrite(2'd0, 32'hFFFF_FFFF);
    walk(32'h0000_0000, 1, 32'hCAFE_0003);
    cfgWrite(2'd2, 32'd0);
    walk(32'h0050_0000, 1, 32'hCAFE_0001);

    phaseTag = "R7";
    // Miss held off while a walk is outstanding
    @(negedge clk);
    missValid = 1'b1; missVa = 32'h0230_0000;
    @(negedge clk);
    missVa = 32'hFF80_0000;                  // stays asserted during the walk
    repeat (3) @(negedge clk);
    chk(missReady === 1'b0, "R7", "held off", 32'(missReady), 32'h0);
    memRspValid = 1'b1; memRspData = 32'h1234_0002;
    @(negedge clk);
    memRspValid = 1'b0;
    @(negedge clk);                          // second miss accepted here
    missValid = 1'b0;
    repeat (2) @(negedge clk);
    memRspValid = 1'b1; memRspData = 32'h0000_0000;
    @(negedge clk);
    memRspValid = 1'b0;
    repeat (3) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule